// File: doc/BRIEF.md
# I2C Multi-Address Slave Comparator

This block decides whether an I2C slave address, already deserialized by the bit engine, belongs to this device. When the bit engine finishes the first byte of a transfer, it pulses a one-cycle strobe that carries the 7 address bits and the R/W bit. The comparator checks the address against the programmed own addresses and against the general-call address. If there is a hit, it sets a sticky match flag. The flag stays set until software writes the status register, disables the interface, or resets it.

The number of own-address registers is a parameter, three by default. A multi-address enable decides whether all registers take part in the compare or only register 0. Matching is allowed only while the controller is in slave receive mode and the addressing format is selected. In free format every strobe is ignored. A general-call indication and the index of the matching register are captured together with the flag.

Top module: `slv_addr_cmp`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `match_flag`, `gcall_flag` and `match_idx` become 0 after that edge (synchronous active-low reset).
- R2: A strobe (`rx_valid`=1) can set the outputs only when `slave_rx_mode`=1 and `fmt_free`=0. With `slave_rx_mode`=0 or `fmt_free`=1, the strobe leaves every output unchanged.
- R3: With `multi_en`=1, the strobed address is compared with every own-address register. A match with any one of them sets `match_flag` at the clock edge that samples the strobe.
- R4: With `multi_en`=0, only register 0 (`own_addr[6:0]`) is compared. A match with register 1 (`own_addr[13:7]`) or register 2 (`own_addr[20:14]`) has no effect.
- R5: A qualified strobe carrying address 7'b0000000 sets `match_flag` and `gcall_flag`, whatever the programmed addresses are. A qualified hit on any other address stores `gcall_flag`=0.
- R6: On a hit, `match_idx` stores the lowest-numbered enabled register that matches. When only the general-call address matched, it stores 0.
- R7: The R/W bit `rx_rw` does not take part in the compare.
- R8: Each of `stat_wr`, `if_disable` and `if_reset`, when high at a clock edge, clears `match_flag`, `gcall_flag` and `match_idx` to 0 at that edge.
- R9: When a clear source and a qualified hit occur in the same cycle, the clear wins and all outputs become 0.
- R10: Without a clear source, the outputs keep their value through idle cycles and through strobes that do not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: received address byte is valid |
| rx_addr | input | 7 | Received 7-bit slave address |
| rx_rw | input | 1 | Received R/W bit (not compared) |
| slave_rx_mode | input | 1 | Controller is in slave receive mode |
| fmt_free | input | 1 | 1 = free format, 0 = addressing format |
| multi_en | input | 1 | 1 = compare against all own-address registers |
| own_addr | input | 21 | Own-address registers, register k in bits [7k+6:7k] |
| stat_wr | input | 1 | Status register write (clear source) |
| if_disable | input | 1 | Interface disable (clear source) |
| if_reset | input | 1 | Interface reset control (clear source) |
| match_flag | output | 1 | Sticky address-match flag |
| gcall_flag | output | 1 | The stored hit was a general call |
| match_idx | output | 2 | Index of the matching own-address register |

## Verification
Every result is registered once, so the outputs after a strobe, a clear or a reset are due at the first rising edge that samples that input. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the edge that updates them. The sweep covers every 7-bit address under both multi-address settings and all four mode/format combinations, and clears the flag before each strobe so that each strobe is judged on its own. Directed sequences then hold a set flag across idle cycles and non-hitting strobes, and issue clears together with hits.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;
   localparam int unsigned SA_ADDR_W = 7;
   localparam int unsigned SA_NUM    = 3;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef struct packed {
      logic set;
      logic gcall;
   } hit_info_t;
endpackage

// File: rtl/addr_cmp_bank.sv
module addr_cmp_bank #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned NUM_ADDR = 3
) (
   input  logic [ADDR_W-1:0]          rx_addr,
   input  logic [NUM_ADDR*ADDR_W-1:0] own_addr,
   input  logic                       multi_en,
   output logic [NUM_ADDR-1:0]        hit_vec
);
   for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cmp
      logic eq;
      assign eq = (rx_addr == own_addr[g*ADDR_W +: ADDR_W]);
      if (g == 0) begin : g_base
         assign hit_vec[g] = eq;
      end else begin : g_extra
         assign hit_vec[g] = eq & multi_en;
      end
   end
endmodule

// File: rtl/low_idx_enc.sv
module low_idx_enc #(
   parameter int unsigned N     = 3,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   if (N == 1) begin : g_single
      assign idx = '0;
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/match_flag_reg.sv
module match_flag_reg #(
   parameter int unsigned IDX_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  slv_addr_pkg::hit_info_t  hit,
   input  logic [IDX_W-1:0]         hit_idx,
   output logic                     flag_q,
   output logic                     gcall_q,
   output logic [IDX_W-1:0]         idx_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         flag_q  <= 1'b0;
         gcall_q <= 1'b0;
         idx_q   <= '0;
      end else if (hit.set) begin
         flag_q  <= 1'b1;
         gcall_q <= hit.gcall;
         idx_q   <= hit_idx;
      end
   end
endmodule

// File: rtl/slv_addr_cmp.sv
module slv_addr_cmp #(
   parameter int unsigned ADDR_W   = slv_addr_pkg::SA_ADDR_W,
   parameter int unsigned NUM_ADDR = slv_addr_pkg::SA_NUM,
   localparam int unsigned IDX_W   = slv_addr_pkg::idx_width(NUM_ADDR)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rx_valid,
   input  logic [ADDR_W-1:0]          rx_addr,
   input  logic                       rx_rw,
   input  logic                       slave_rx_mode,
   input  logic                       fmt_free,
   input  logic                       multi_en,
   input  logic [NUM_ADDR*ADDR_W-1:0] own_addr,
   input  logic                       stat_wr,
   input  logic                       if_disable,
   input  logic                       if_reset,
   output logic                       match_flag,
   output logic                       gcall_flag,
   output logic [IDX_W-1:0]           match_idx
);
   import slv_addr_pkg::*;

   if (ADDR_W < 1) begin : g_bad_w
      $error("slv_addr_cmp: ADDR_W must be at least 1");
   end
   if (NUM_ADDR < 1) begin : g_bad_n
      $error("slv_addr_cmp: NUM_ADDR must be at least 1");
   end
   if ((1 << IDX_W) < NUM_ADDR) begin : g_bad_idx
      $error("slv_addr_cmp: index width too narrow");
   end

   logic [NUM_ADDR-1:0] hit_vec;
   logic                any_hit;
   logic [IDX_W-1:0]    hit_idx;
   logic                qualified;
   logic                is_gcall;
   logic                clr;
   hit_info_t           hit;

   addr_cmp_bank #(.ADDR_W(ADDR_W), .NUM_ADDR(NUM_ADDR)) u_bank (
      .rx_addr  (rx_addr),
      .own_addr (own_addr),
      .multi_en (multi_en),
      .hit_vec  (hit_vec)
   );

   low_idx_enc #(.N(NUM_ADDR), .IDX_W(IDX_W)) u_enc (
      .req (hit_vec),
      .any (any_hit),
      .idx (hit_idx)
   );

   // R/W bit is received alongside the address but never compared
   logic unused_rw;
   assign unused_rw = rx_rw;

   assign qualified = rx_valid & slave_rx_mode & ~fmt_free;
   assign is_gcall  = (rx_addr == '0);
   assign clr       = stat_wr | if_disable | if_reset;
   assign hit.set   = qualified & (any_hit | is_gcall);
   assign hit.gcall = is_gcall;

   match_flag_reg #(.IDX_W(IDX_W)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .hit     (hit),
      .hit_idx (hit_idx),
      .flag_q  (match_flag),
      .gcall_q (gcall_flag),
      .idx_q   (match_idx)
   );
endmodule

// File: rtl/slv_addr_cmp_chk.sv
module slv_addr_cmp_chk #(
   parameter int unsigned IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             slave_rx_mode,
   input logic             fmt_free,
   input logic             multi_en,
   input logic             stat_wr,
   input logic             if_disable,
   input logic             if_reset,
   input logic             match_flag,
   input logic             gcall_flag,
   input logic [IDX_W-1:0] match_idx
);
   logic clr_any;
   assign clr_any = stat_wr | if_disable | if_reset;

   assert_set_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> $past(rx_valid && slave_rx_mode && !fmt_free))
      else $error("match flag set without a qualified strobe");

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_any |=> (!match_flag && !gcall_flag && match_idx == '0))
      else $error("clear source did not clear the outputs");

   assert_gcall_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_flag |-> match_flag)
      else $error("general call indicated without match flag");

   assert_single_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !multi_en) |=> (match_idx == '0 || $stable(match_idx)))
      else $error("non-zero index captured with multi-address disabled");

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_valid && !clr_any) |=>
         ($stable(match_flag) && $stable(gcall_flag) && $stable(match_idx)))
      else $error("outputs changed without strobe or clear");
endmodule

bind slv_addr_cmp slv_addr_cmp_chk #(.IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_valid      (rx_valid),
   .slave_rx_mode (slave_rx_mode),
   .fmt_free      (fmt_free),
   .multi_en      (multi_en),
   .stat_wr       (stat_wr),
   .if_disable    (if_disable),
   .if_reset      (if_reset),
   .match_flag    (match_flag),
   .gcall_flag    (gcall_flag),
   .match_idx     (match_idx)
);

// File: tb/tb_slv_addr_cmp.sv
module tb_slv_addr_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [6:0]  rx_addr = '0;
   logic        rx_rw = 1'b0;
   logic        slave_rx_mode = 1'b0;
   logic        fmt_free = 1'b0;
   logic        multi_en = 1'b0;
   logic [20:0] own_addr = '0;
   logic        stat_wr = 1'b0;
   logic        if_disable = 1'b0;
   logic        if_reset = 1'b0;
   logic        match_flag;
   logic        gcall_flag;
   logic [1:0]  match_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   slv_addr_cmp dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_addr(rx_addr),
      .rx_rw(rx_rw), .slave_rx_mode(slave_rx_mode), .fmt_free(fmt_free),
      .multi_en(multi_en), .own_addr(own_addr), .stat_wr(stat_wr),
      .if_disable(if_disable), .if_reset(if_reset), .match_flag(match_flag),
      .gcall_flag(gcall_flag), .match_idx(match_idx)
   );

   task automatic check_out(input string req, input logic ef, input logic eg,
                            input logic [1:0] ei);
      n_chk++;
      if (match_flag !== ef || gcall_flag !== eg || match_idx !== ei) begin
         n_bad++;
         $display("FAIL %s: got flag=%b gcall=%b idx=%0d, expected flag=%b gcall=%b idx=%0d",
                  req, match_flag, gcall_flag, match_idx, ef, eg, ei);
      end
   endtask

   // drive a one-cycle strobe (plus optional clear) at a falling edge,
   // return at the next falling edge, after the sampling posedge
   task automatic strobe(input logic [6:0] a, input logic rw, input logic clr);
      rx_valid = 1'b1; rx_addr = a; rx_rw = rw; stat_wr = clr;
      @(negedge clk);
      rx_valid = 1'b0; stat_wr = 1'b0;
   endtask

   task automatic pulse_clear(input int which);
      stat_wr = (which == 0); if_disable = (which == 1); if_reset = (which == 2);
      @(negedge clk);
      stat_wr = 1'b0; if_disable = 1'b0; if_reset = 1'b0;
   endtask

   logic [6:0] ra0, ra1, ra2;

   initial begin
      ra0 = 7'h2A; ra1 = 7'h55; ra2 = 7'h13;
      own_addr = {ra2, ra1, ra0};
      repeat (3) @(negedge clk);
      check_out("R1 reset state", 1'b0, 1'b0, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: multi enable, mode/format, every address
      for (int m = 0; m < 2; m++) begin
         for (int md = 0; md < 4; md++) begin
            multi_en = m[0];
            slave_rx_mode = md[0];
            fmt_free = md[1];
            for (int a = 0; a < 128; a++) begin
               logic q, h0, h1, h2, gc, hit, eg;
               logic [1:0] ei;
               pulse_clear(0);
               q  = slave_rx_mode && !fmt_free;
               h0 = (7'(a) == ra0);
               h1 = m[0] && (7'(a) == ra1);
               h2 = m[0] && (7'(a) == ra2);
               gc = (a == 0);
               hit = q && (h0 || h1 || h2 || gc);
               eg = hit && gc;
               ei = !hit ? 2'd0 : h0 ? 2'd0 : h1 ? 2'd1 : h2 ? 2'd2 : 2'd0;
               // R/W bit toggled against the address LSB to show it is ignored (R7)
               strobe(7'(a), a[0] ^ m[0], 1'b0);
               check_out(!q ? "R2 qualify" : (m != 0 ? "R3 multi compare" :
                         "R4 single compare"), hit, eg, ei);
            end
         end
      end

      // general call with register 1 set to zero: R5 and R6 (lowest index wins)
      slave_rx_mode = 1'b1; fmt_free = 1'b0; multi_en = 1'b1;
      own_addr = {ra2, 7'h00, ra0};
      pulse_clear(0);
      strobe(7'h00, 1'b1, 1'b0);
      check_out("R5 gcall with own zero, R6 idx", 1'b1, 1'b1, 2'd1);

      // duplicate addresses in registers 1 and 2: R6
      own_addr = {7'h33, 7'h33, ra0};
      pulse_clear(0);
      strobe(7'h33, 1'b0, 1'b0);
      check_out("R6 lowest index", 1'b1, 1'b0, 2'd1);

      // sticky across idle and non-hitting strobe: R10
      repeat (4) @(negedge clk);
      check_out("R10 idle hold", 1'b1, 1'b0, 2'd1);
      strobe(7'h7F, 1'b0, 1'b0);
      check_out("R10 miss hold", 1'b1, 1'b0, 2'd1);
      fmt_free = 1'b1;
      strobe(7'h00, 1'b0, 1'b0);
      check_out("R2 free format ignored", 1'b1, 1'b0, 2'd1);
      fmt_free = 1'b0;

      // new hit replaces stored index and gcall
      strobe(7'h00, 1'b0, 1'b0);
      check_out("R5 gcall replaces", 1'b1, 1'b1, 2'd0);

      // each clear source: R8
      for (int c = 0; c < 3; c++) begin
         strobe(7'h33, 1'b1, 1'b0);
         check_out("R8 preset", 1'b1, 1'b0, 2'd1);
         pulse_clear(c);
         check_out("R8 clear source", 1'b0, 1'b0, 2'd0);
      end

      // clear and hit together: R9
      strobe(7'h33, 1'b0, 1'b1);
      check_out("R9 clear beats set", 1'b0, 1'b0, 2'd0);
      rx_valid = 1'b1; rx_addr = 7'h00; if_reset = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; if_reset = 1'b0;
      check_out("R9 reset control beats gcall", 1'b0, 1'b0, 2'd0);

      // synchronous reset mid-run: R1
      strobe(7'h00, 1'b0, 1'b0);
      check_out("R1 preset", 1'b1, 1'b1, 2'd0);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1 sync reset", 1'b0, 1'b0, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule